// File: doc/BRIEF.md
# Frame-Gated Memory Read Controller

This block decides when a stored video frame may be fetched from external memory. It keeps a count of frames that have been fully written into memory but not yet streamed out. The writer sends a one-cycle completion pulse after each frame it stores, and the reader sends one after each frame it delivers. A read burst is launched only when reading is enabled and at least one frame is pending.

A small state machine has three states: `ST_RESET`, `ST_IDLE` and `ST_READ`. Its transitions are as follows:

- `ST_RESET` always moves to `ST_IDLE` on the first clock after reset is released.
- `ST_IDLE` moves to `ST_READ` (the *launch* transition) when reading is enabled and the pending count is non-zero.
- `ST_READ` moves back to `ST_IDLE` (the *finish* transition) when the memory port signals that the transfer is complete.

On launch, the controller emits a one-cycle start command and captures the configured base address for the memory port. It does not buffer any data itself.

Top module: `frame_read_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `rd_start`, `busy`, `pend_count`, `pend_overflow` and `rd_addr` are all zero.
- R2: A launch happens at a clock edge where the controller is idle, `rd_enable` is 1 and the registered `pend_count` is non-zero. After that edge, `rd_start` is 1 for exactly one cycle, `busy` is 1, and `rd_addr` holds the value `cfg_base_addr` had at that edge.
- R3: No launch happens while `pend_count` is zero or while `rd_enable` is 0.
- R4: `busy` stays 1 until an edge where `xfer_done` is 1, and is 0 after that edge. `xfer_done` while idle has no effect.
- R5: After each edge, `pend_count` has risen by one if only `wr_frame_done` was 1, or fallen by one if only `rd_frame_done` was 1. It is unchanged if both pulses, or neither, were 1.
- R6: `pend_count` saturates at zero and at 2^CNT_W-1. A lone write pulse at the maximum sets `pend_overflow`, which then stays 1 until reset.
- R7: Clearing `rd_enable` during a read lets the read finish on `xfer_done`. After that, no launch occurs while `rd_enable` stays 0, whatever the count.
- R8: `rd_addr` changes only at a launch. It ignores `cfg_base_addr` at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_frame_done | input | 1 | Pulse: writer finished storing a frame |
| rd_frame_done | input | 1 | Pulse: reader finished streaming a frame |
| rd_enable | input | 1 | Configuration: reading allowed |
| xfer_done | input | 1 | Memory port: current burst transfer complete |
| cfg_base_addr | input | ADDR_W | Configured base of the frame region |
| rd_start | output | 1 | One-cycle read command to the memory port |
| rd_addr | output | ADDR_W | Base address captured at launch |
| busy | output | 1 | Controller is in the read state |
| pend_count | output | CNT_W | Frames stored but not yet streamed |
| pend_overflow | output | 1 | Sticky: a write pulse arrived while the count was full |

## Verification
The hardest case to reach is the count at its saturation limit while a read is already under way. Reaching the limit needs several write pulses with no read pulses in between, and a launch must also be allowed to occur. The bench shrinks the counter to two bits and clears `rd_enable` so that no read starts while writes pile up. It then drives a fourth write to hit the limit and set the sticky flag. Only after that does it re-enable reading, moving the configured address in the same cycle, to show which value is captured at launch.

// File: rtl/frc_pkg.sv
package frc_pkg;
    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_IDLE  = 2'd1,
        ST_READ  = 2'd2
    } frc_state_e;
endpackage

// File: rtl/frc_pend_counter.sv
module frc_pend_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             overflow
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic at_max;
    logic at_zero;

    assign at_max  = (count == CNT_MAX);
    assign at_zero = (count == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (inc && !dec) begin
                if (at_max) begin
                    overflow <= 1'b1;
                end else begin
                    count <= count + CNT_ONE;
                end
            end else if (dec && !inc && !at_zero) begin
                count <= count - CNT_ONE;
            end
        end
    end
endmodule

// File: rtl/frc_fsm.sv
module frc_fsm
    import frc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_enable,
    input  logic              frame_ready,
    input  logic              xfer_done,
    input  logic [ADDR_W-1:0] cfg_base_addr,
    output logic              rd_start,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              busy
);
    frc_state_e state_q;
    frc_state_e state_d;
    logic       launch;

    always_comb begin
        state_d = state_q;
        launch  = 1'b0;
        unique case (state_q)
            ST_RESET: state_d = ST_IDLE;
            ST_IDLE: begin
                if (rd_enable && frame_ready) begin
                    state_d = ST_READ;
                    launch  = 1'b1;
                end
            end
            ST_READ: begin
                if (xfer_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_start <= 1'b0;
            rd_addr  <= '0;
        end else begin
            rd_start <= launch;
            if (launch) begin
                rd_addr <= cfg_base_addr;
            end
        end
    end

    assign busy = (state_q == ST_READ);
endmodule

// File: rtl/frame_read_ctrl.sv
module frame_read_ctrl #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_frame_done,
    input  logic              rd_frame_done,
    input  logic              rd_enable,
    input  logic              xfer_done,
    input  logic [ADDR_W-1:0] cfg_base_addr,
    output logic              rd_start,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              busy,
    output logic [CNT_W-1:0]  pend_count,
    output logic              pend_overflow
);
    logic frame_ready;

    assign frame_ready = (pend_count != '0);

    frc_pend_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (wr_frame_done),
        .dec      (rd_frame_done),
        .count    (pend_count),
        .overflow (pend_overflow)
    );

    frc_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd_enable     (rd_enable),
        .frame_ready   (frame_ready),
        .xfer_done     (xfer_done),
        .cfg_base_addr (cfg_base_addr),
        .rd_start      (rd_start),
        .rd_addr       (rd_addr),
        .busy          (busy)
    );
endmodule

// File: rtl/frc_checker.sv
module frc_checker #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_frame_done,
    input logic              rd_frame_done,
    input logic              rd_enable,
    input logic              xfer_done,
    input logic [ADDR_W-1:0] cfg_base_addr,
    input logic              rd_start,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              busy,
    input logic [CNT_W-1:0]  pend_count,
    input logic              pend_overflow
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |-> busy);
    assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> !rd_start);
    assert_no_empty_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (pend_count == '0 || !rd_enable)) |=> !rd_start);
    assert_busy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !xfer_done) |=> busy);
    assert_busy_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && xfer_done) |=> !busy);
    assert_count_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_frame_done && !rd_frame_done && pend_count != CNT_MAX)
        |=> pend_count == $past(pend_count) + CNT_W'(1));
    assert_count_same_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_frame_done == rd_frame_done) |=> $stable(pend_count));
    assert_sticky_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pend_overflow |=> pend_overflow);
    assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_start |-> $stable(rd_addr));
endmodule

bind frame_read_ctrl frc_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_frame_done (wr_frame_done),
    .rd_frame_done (rd_frame_done),
    .rd_enable     (rd_enable),
    .xfer_done     (xfer_done),
    .cfg_base_addr (cfg_base_addr),
    .rd_start      (rd_start),
    .rd_addr       (rd_addr),
    .busy          (busy),
    .pend_count    (pend_count),
    .pend_overflow (pend_overflow)
);

// File: tb/sim_frame_read_ctrl.sv
`timescale 1ns/1ps
module sim_frame_read_ctrl;
    localparam int AW = 16;
    localparam int CW = 2;

    typedef struct packed {
        logic          st;
        logic          bz;
        logic [CW-1:0] cnt;
        logic          ov;
        logic [AW-1:0] ad;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr = 1'b0, rd = 1'b0, en = 1'b0, xd = 1'b0;
    logic [AW-1:0] base = 16'h1000;
    logic          rd_start, busy, ovf;
    logic [AW-1:0] addr;
    logic [CW-1:0] cnt;

    int    vectors = 0;
    int    miscompares = 0;
    bit    finished = 1'b0;
    exp_t  exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    frame_read_ctrl #(.ADDR_W(AW), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_frame_done(wr), .rd_frame_done(rd),
        .rd_enable(en), .xfer_done(xd), .cfg_base_addr(base),
        .rd_start(rd_start), .rd_addr(addr), .busy(busy),
        .pend_count(cnt), .pend_overflow(ovf)
    );

    task automatic compare(input exp_t e, input string tag);
        exp_t got;
        got = '{st: rd_start, bz: busy, cnt: cnt, ov: ovf, ad: addr};
        vectors++;
        if (got !== e) begin
            miscompares++;
            $display("FAIL %s: got start=%0b busy=%0b cnt=%0d ovf=%0b addr=%h, expected start=%0b busy=%0b cnt=%0d ovf=%0b addr=%h",
                     tag, got.st, got.bz, got.cnt, got.ov, got.ad,
                     e.st, e.bz, e.cnt, e.ov, e.ad);
        end
    endtask

    // driver: drive one cycle of stimulus, queue outputs expected after the next edge
    task automatic cyc(input logic w, input logic r, input logic e, input logic x,
                       input logic [AW-1:0] b,
                       input logic es, input logic eb, input int ec, input logic eo,
                       input logic [AW-1:0] ea, input string tag);
        @(negedge clk);
        wr = w; rd = r; en = e; xd = x; base = b;
        exp_q.push_back('{st: es, bz: eb, cnt: CW'(ec), ov: eo, ad: ea});
        tag_q.push_back(tag);
    endtask

    // monitor
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            compare(exp_q.pop_front(), tag_q.pop_front());
        end
    end

    initial begin
        #20000;
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        compare('{st: 0, bz: 0, cnt: '0, ov: 0, ad: '0}, "R1 in reset");
        rst_n = 1'b1;
        //   wr rd en xd base       st bz cnt ov addr
        cyc(0, 0, 0, 0, 16'h1000, 0, 0, 0, 0, 16'h0000, "R1 first cycle");
        cyc(0, 0, 1, 0, 16'h1000, 0, 0, 0, 0, 16'h0000, "R3 empty no launch");
        cyc(1, 0, 1, 0, 16'h1000, 0, 0, 1, 0, 16'h0000, "R5 write increments");
        cyc(0, 0, 1, 0, 16'h1000, 1, 1, 1, 0, 16'h1000, "R2 launch");
        cyc(0, 0, 1, 0, 16'h1000, 0, 1, 1, 0, 16'h1000, "R2 single pulse");
        cyc(1, 0, 1, 0, 16'h1000, 0, 1, 2, 0, 16'h1000, "R5 write during read");
        cyc(0, 1, 1, 1, 16'h1000, 0, 0, 1, 0, 16'h1000, "R4 finish on xfer_done");
        cyc(0, 0, 1, 0, 16'h1000, 1, 1, 1, 0, 16'h1000, "R2 relaunch");
        cyc(1, 1, 0, 0, 16'h1000, 0, 1, 1, 0, 16'h1000, "R5 both pulses / R7 disable mid-read");
        cyc(0, 0, 0, 0, 16'h1000, 0, 1, 1, 0, 16'h1000, "R7 read continues");
        cyc(0, 0, 0, 1, 16'h1000, 0, 0, 1, 0, 16'h1000, "R7 read finishes");
        cyc(0, 0, 0, 0, 16'h1000, 0, 0, 1, 0, 16'h1000, "R3 disabled holds idle");
        cyc(1, 0, 0, 0, 16'h1000, 0, 0, 2, 0, 16'h1000, "R7 idle while disabled");
        cyc(1, 0, 0, 0, 16'h1000, 0, 0, 3, 0, 16'h1000, "R5 count to max");
        cyc(1, 0, 0, 0, 16'h1000, 0, 0, 3, 1, 16'h1000, "R6 saturate and overflow");
        cyc(1, 1, 0, 0, 16'h1000, 0, 0, 3, 1, 16'h1000, "R6 both at max no change");
        cyc(0, 0, 0, 0, 16'h1000, 0, 0, 3, 1, 16'h1000, "R6 overflow sticky");
        cyc(0, 0, 1, 0, 16'h2000, 1, 1, 3, 1, 16'h2000, "R2 address captured");
        cyc(0, 1, 1, 0, 16'h3000, 0, 1, 2, 1, 16'h2000, "R8 address held");
        cyc(0, 1, 0, 1, 16'h3000, 0, 0, 1, 1, 16'h2000, "R4 finish");
        cyc(0, 1, 0, 0, 16'h4000, 0, 0, 0, 1, 16'h2000, "R5 decrement");
        cyc(0, 1, 0, 0, 16'h4000, 0, 0, 0, 1, 16'h2000, "R6 saturate at zero");
        cyc(0, 0, 1, 1, 16'h4000, 0, 0, 0, 1, 16'h2000, "R4 xfer_done idle ignored");
        cyc(0, 0, 0, 0, 16'h4000, 0, 0, 0, 1, 16'h2000, "R8 idle address held");
        @(negedge clk);
        wr = 0; rd = 0; en = 0; xd = 0;
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule